// File: doc/BRIEF.md
# SPI Go-Back Block Receiver

This block is an SPI mode 0 slave that takes fixed-length blocks from a master. A block is one sequence ID byte, then a payload of `PAY_N` bytes (32 by default), then a 16-bit checksum, then two filler bytes. While the master clocks a block in, the slave clocks an acknowledgement back on MISO. The acknowledgement is the ID of the last block it accepted. A master that sees an unexpected acknowledgement rewinds to the oldest unacknowledged block and sends again from there.

A block is accepted only when three conditions hold: its ID follows the last accepted one, its checksum matches, and the payload buffer was free when the block began. An accepted block updates the acknowledgement at once. The new value goes out in the two filler bytes of the same block, so the master learns the outcome without waiting for the next block. Accepted payload bytes go downstream over a valid/ready pair. The receiver refuses new blocks while the buffer still holds undelivered data, and this refusal is the flow control.

The SPI pins are sampled in the system clock domain through two-flop synchronisers. Data is captured on detected SCLK rising edges and MISO is shifted on detected falling edges. SCLK must therefore run several times slower than the system clock.

Top module: `spi_gbr_rx`

## Requirements
- R1: In bytes 0 and 1 of every block, MISO returns the last accepted ID and then its bitwise complement. Bytes 2 through `PAY_N`+2 return 8'h00. All bytes are sent MSB first.
- R2: In bytes `PAY_N`+3 and `PAY_N`+4 of the same block, MISO returns the last accepted ID and its complement. These values already reflect the verdict on that block.
- R3: A block is accepted only if bytes `PAY_N`+1 (high) and `PAY_N`+2 (low) equal the 16-bit wrapping sum of the ID byte and all payload bytes.
- R4: The accepted ID resets to 8'hFF. A block is accepted only if its ID equals the accepted ID plus one, modulo 256. Any other ID, duplicates included, is discarded even when its checksum is valid.
- R5: Payload bytes of an accepted block are presented on out_data in arrival order, only after acceptance. While out_valid is high and out_ready is low, out_valid and out_data hold.
- R6: A block whose ID byte completes while payload from an earlier block is still undelivered is rejected, and the accepted ID does not change.
- R7: Driving spi_cs_n high part-way through a block abandons that block. The next block after CS_n goes low again starts at byte 0.
- R8: When CS_n stays low after the last byte of a block, the next byte is byte 0 of a new block.
- R9: After reset, out_valid is low and the first MISO bit is the MSB of 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial acknowledgement data to the master |
| out_valid | output | 1 | Payload byte available |
| out_data | output | 8 | Payload byte |
| out_ready | input | 1 | Downstream can take a byte |

## Verification
The acknowledgement is a pure function of block position. The bench therefore captures every MISO bit at the instant it raises SCLK, about three system clocks after the slave shifted that bit. It then compares bytes 0, 1 and the two filler bytes against a behavioural model of the accepted ID. The verdict on a block lands two system clocks after the last checksum bit is sampled, and out_valid rises one clock after that. This is well before the filler bytes begin, so the same-block acknowledgement is a valid check. Payload is compared against a model queue on every clock edge where out_valid and out_ready are both high, with the signals sampled on the falling system clock edge. Whether each block was consumed in full is checked only after the bench has allowed the 32-cycle drain to finish.

// File: rtl/spi_gbr_pkg.sv
package spi_gbr_pkg;

    localparam int PAY_BYTES_DEF = 32;
    localparam int SYNC_DEPTH_DEF = 2;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } byte_ev_t;

    typedef enum logic {
        BUF_IDLE  = 1'b0,
        BUF_DRAIN = 1'b1
    } buf_state_e;

    function automatic logic [15:0] sum_step(input logic [15:0] acc, input logic [7:0] b);
        return acc + {8'h00, b};
    endfunction

endpackage

// File: rtl/spi_gbr_sync.sv
module spi_gbr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic mosi_in,
    input  logic cs_n_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s,
    output logic cs_act
);
    // bit 2: cs_n, bit 1: mosi, bit 0: sclk
    logic [2:0] chain [STAGES];
    logic       sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 3'b100;
        else     chain[0] <= {cs_n_in, mosi_in, sclk_in};
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 3'b100;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= chain[STAGES-1][0];
    end

    assign sclk_rise = chain[STAGES-1][0] & ~sclk_prev;
    assign sclk_fall = ~chain[STAGES-1][0] & sclk_prev;
    assign mosi_s    = chain[STAGES-1][1];
    assign cs_act    = ~chain[STAGES-1][2];

endmodule

// File: rtl/spi_gbr_shift.sv
module spi_gbr_shift
    import spi_gbr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_rise,
    input  logic     sclk_fall,
    input  logic     mosi_s,
    input  logic     cs_act,
    input  logic [7:0] tx_byte,
    output byte_ev_t rx_ev,
    output logic     miso
);
    logic [2:0] bitcnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            bitcnt <= '0;
            rx_sh  <= '0;
            tx_sh  <= 8'hFF;
            rx_ev  <= '0;
        end else begin
            rx_ev.valid <= 1'b0;
            if (!cs_act) begin
                bitcnt <= '0;
                tx_sh  <= tx_byte;
            end else begin
                if (sclk_rise) begin
                    rx_sh  <= {rx_sh[6:0], mosi_s};
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) begin
                        rx_ev.valid <= 1'b1;
                        rx_ev.data  <= {rx_sh[6:0], mosi_s};
                    end
                end
                if (sclk_fall) begin
                    if (bitcnt == 3'd0) tx_sh <= tx_byte;
                    else                tx_sh <= {tx_sh[6:0], 1'b0};
                end
            end
        end
    end

    assign miso = tx_sh[7];

    // R7: a released chip select restarts bit counting
    a_r7_bit_restart: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (bitcnt == 3'd0))
        else $error("a_r7_bit_restart");

endmodule

// File: rtl/spi_gbr_frame.sv
module spi_gbr_frame
    import spi_gbr_pkg::*;
#(
    parameter int PAY_N = PAY_BYTES_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_act,
    input  byte_ev_t rx_ev,
    input  logic     buf_busy,
    output logic [7:0] tx_byte,
    output logic     wr_en,
    output logic [$clog2(PAY_N)-1:0] wr_addr,
    output logic [7:0] wr_data,
    output logic     commit
);
    localparam int FRAME_N  = PAY_N + 5;
    localparam int IW       = $clog2(FRAME_N);
    localparam int AW       = $clog2(PAY_N);
    localparam int POS_CKH  = PAY_N + 1;
    localparam int POS_CKL  = PAY_N + 2;
    localparam int POS_ACK  = PAY_N + 3;
    localparam int POS_NACK = PAY_N + 4;

    logic [IW-1:0] idx;
    logic [15:0]   sum;
    logic [7:0]    ck_hi;
    logic [7:0]    rx_id;
    logic [7:0]    last_good;
    logic          stage_ok;
    logic          in_payload;
    logic          accept;
    logic [IW-1:0] pay_off;

    assign in_payload = (idx >= IW'(1)) && (idx <= IW'(PAY_N));
    assign pay_off    = idx - IW'(1);
    assign wr_en      = cs_act && rx_ev.valid && in_payload && stage_ok;
    assign wr_addr    = pay_off[AW-1:0];
    assign wr_data    = rx_ev.data;

    assign accept = stage_ok && !buf_busy
                 && (rx_id == last_good + 8'd1)
                 && ({ck_hi, rx_ev.data} == sum);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            sum       <= '0;
            ck_hi     <= '0;
            rx_id     <= '0;
            stage_ok  <= 1'b0;
            last_good <= 8'hFF;
            commit    <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (!cs_act) begin
                idx      <= '0;
                sum      <= '0;
                stage_ok <= 1'b0;
            end else if (rx_ev.valid) begin
                if (idx == '0) begin
                    rx_id    <= rx_ev.data;
                    sum      <= sum_step(16'h0000, rx_ev.data);
                    stage_ok <= !buf_busy;
                end else if (in_payload) begin
                    sum <= sum_step(sum, rx_ev.data);
                end else if (idx == IW'(POS_CKH)) begin
                    ck_hi <= rx_ev.data;
                end else if (idx == IW'(POS_CKL)) begin
                    if (accept) begin
                        last_good <= rx_id;
                        commit    <= 1'b1;
                    end
                end
                idx <= (idx == IW'(FRAME_N - 1)) ? '0 : idx + IW'(1);
            end
        end
    end

    always_comb begin
        if (idx == '0)                   tx_byte = last_good;
        else if (idx == IW'(1))          tx_byte = ~last_good;
        else if (idx == IW'(POS_ACK))    tx_byte = last_good;
        else if (idx == IW'(POS_NACK))   tx_byte = ~last_good;
        else                             tx_byte = 8'h00;
    end

    // R4: the acknowledged ID only ever advances by one
    a_r4_id_step: assert property (@(posedge clk) disable iff (rst)
        (last_good != $past(last_good)) |-> (last_good == $past(last_good) + 8'd1))
        else $error("a_r4_id_step");

    // R6: a block is never committed into a buffer that still drains
    a_r6_commit_idle: assert property (@(posedge clk) disable iff (rst)
        commit |-> !buf_busy)
        else $error("a_r6_commit_idle");

    // R7: chip select release returns the frame to byte 0
    a_r7_frame_restart: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (idx == '0))
        else $error("a_r7_frame_restart");

endmodule

// File: rtl/spi_gbr_buf.sv
module spi_gbr_buf
    import spi_gbr_pkg::*;
#(
    parameter int PAY_N = PAY_BYTES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic [$clog2(PAY_N)-1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic commit,
    input  logic out_ready,
    output logic out_valid,
    output logic [7:0] out_data,
    output logic busy
);
    localparam int AW = $clog2(PAY_N);

    logic [7:0]  mem [PAY_N];
    logic [AW-1:0] rd;
    buf_state_e  st;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= BUF_IDLE;
            rd <= '0;
        end else begin
            case (st)
                BUF_IDLE: if (commit) begin
                    st <= BUF_DRAIN;
                    rd <= '0;
                end
                BUF_DRAIN: if (out_ready) begin
                    if (rd == AW'(PAY_N - 1)) st <= BUF_IDLE;
                    rd <= rd + AW'(1);
                end
                default: st <= BUF_IDLE;
            endcase
        end
    end

    assign busy      = (st == BUF_DRAIN);
    assign out_valid = busy;
    assign out_data  = mem[rd];

    // R5: a stalled byte stays put
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
        else $error("a_r5_hold");

    // R5: an accepted block is offered on the next cycle
    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        commit |=> out_valid)
        else $error("a_r5_release");

endmodule

// File: rtl/spi_gbr_rx.sv
module spi_gbr_rx
    import spi_gbr_pkg::*;
#(
    parameter int PAY_N  = PAY_BYTES_DEF,
    parameter int STAGES = SYNC_DEPTH_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sclk,
    input  logic       spi_mosi,
    input  logic       spi_cs_n,
    output logic       spi_miso,
    output logic       out_valid,
    output logic [7:0] out_data,
    input  logic       out_ready
);
    localparam int AW = $clog2(PAY_N);

    logic       sclk_rise, sclk_fall, mosi_s, cs_act;
    byte_ev_t   rx_ev;
    logic [7:0] tx_byte;
    logic       wr_en, commit, buf_busy;
    logic [AW-1:0] wr_addr;
    logic [7:0] wr_data;

    spi_gbr_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sclk_in(spi_sclk), .mosi_in(spi_mosi), .cs_n_in(spi_cs_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .mosi_s(mosi_s), .cs_act(cs_act)
    );

    spi_gbr_shift u_shift (
        .clk(clk), .rst(rst),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .mosi_s(mosi_s), .cs_act(cs_act),
        .tx_byte(tx_byte), .rx_ev(rx_ev), .miso(spi_miso)
    );

    spi_gbr_frame #(.PAY_N(PAY_N)) u_frame (
        .clk(clk), .rst(rst), .cs_act(cs_act), .rx_ev(rx_ev),
        .buf_busy(buf_busy), .tx_byte(tx_byte),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit(commit)
    );

    spi_gbr_buf #(.PAY_N(PAY_N)) u_buf (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit(commit), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .busy(buf_busy)
    );

    // R9: nothing is offered downstream straight after reset
    a_r9_idle_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> !out_valid)
        else $error("a_r9_idle_after_reset");

endmodule

// File: tb/sim_spi_gbr_rx.sv
module sim_spi_gbr_rx;
    localparam int CLK_NS = 10;
    localparam int HALF   = 6;
    localparam int PAY_N  = 32;
    localparam int FRAME_N = PAY_N + 5;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1, out_ready = 1'b1;
    logic miso, out_valid;
    logic [7:0] out_data;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;
    int model_lg = 8'hFF;
    logic [7:0] exp_q[$];

    always #(CLK_NS/2) clk = ~clk;

    spi_gbr_rx #(.PAY_N(PAY_N)) u0 (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
        .spi_miso(miso), .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // per-clock comparison of delivered payload against the model queue (R5)
    always @(negedge clk) begin
        cycles++;
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) chk(0, "R5 unexpected byte", out_data, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(out_data == e, "R5 payload order", out_data, e);
            end
        end
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            chk(0, "watchdog", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            mosi = tx[b];
            wait_n(HALF);
            rx[b] = miso;
            sclk = 1'b1;
            wait_n(HALF);
            sclk = 1'b0;
        end
    endtask

    // one block body with CS already low; nbytes < FRAME_N makes a partial block
    task automatic frame_body(input logic [7:0] id, input logic [7:0] seed,
                              input bit bad, input int nbytes, input bit full);
        logic [7:0] pay [PAY_N];
        logic [7:0] rxb [FRAME_N];
        logic [15:0] s;
        logic [7:0] tmp;
        bit busy0, acc, mid_ok;
        int lg0;
        s = {8'h00, id};
        for (int i = 0; i < PAY_N; i++) begin
            pay[i] = seed + 8'(i * 7);
            s = s + {8'h00, pay[i]};
        end
        if (bad) s = s ^ 16'h0001;
        busy0 = (exp_q.size() != 0);
        lg0 = model_lg;
        acc = full && !busy0 && (id == 8'(lg0 + 1)) && !bad;
        if (acc) begin
            model_lg = id;
            for (int i = 0; i < PAY_N; i++) exp_q.push_back(pay[i]);
        end
        for (int k = 0; k < nbytes; k++) begin
            if (k == 0) tmp = id;
            else if (k <= PAY_N) tmp = pay[k-1];
            else if (k == PAY_N + 1) tmp = s[15:8];
            else if (k == PAY_N + 2) tmp = s[7:0];
            else tmp = 8'h00;
            xfer_byte(tmp, rxb[k]);
        end
        chk(rxb[0] == 8'(lg0), "R1 lead ack", rxb[0], lg0);
        chk(rxb[1] == ~8'(lg0), "R1 lead ack complement", rxb[1], ~8'(lg0));
        if (full) begin
            mid_ok = 1;
            for (int k = 2; k <= PAY_N + 2; k++) if (rxb[k] != 8'h00) mid_ok = 0;
            chk(mid_ok, "R1 middle bytes zero", mid_ok, 1);
            chk(rxb[PAY_N+3] == 8'(model_lg), "R2 trailing ack", rxb[PAY_N+3], model_lg);
            chk(rxb[PAY_N+4] == ~8'(model_lg), "R2 trailing ack complement",
                rxb[PAY_N+4], ~8'(model_lg));
        end
    endtask

    task automatic run_frame(input logic [7:0] id, input logic [7:0] seed, input bit bad);
        cs_n = 1'b0;
        wait_n(HALF);
        frame_body(id, seed, bad, FRAME_N, 1);
        wait_n(HALF);
        cs_n = 1'b1;
        wait_n(4 * HALF);
    endtask

    task automatic drained(input string tag);
        wait_n(3 * PAY_N);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    initial begin
        wait_n(5);
        rst = 1'b0;
        wait_n(3);
        // R9: reset state at the ports
        chk(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
        chk(miso == 1'b1, "R9 first MISO bit", miso, 1);

        // R3 R4: first good block uses ID 00 after FF
        run_frame(8'h00, 8'h11, 0);
        drained("R5 block 0 delivered");
        // R4: duplicate of an accepted block is discarded
        run_frame(8'h00, 8'h22, 0);
        // R4: skipped ID is discarded
        run_frame(8'h02, 8'h33, 0);
        // R3: wrong checksum is discarded
        run_frame(8'h01, 8'h44, 1);
        chk(out_valid == 1'b0, "R3 nothing released on bad checksum", out_valid, 0);

        // R5 R6: accept with downstream stalled, then next block is refused
        out_ready = 1'b0;
        run_frame(8'h01, 8'h55, 0);
        chk(out_valid == 1'b1, "R5 held while stalled", out_valid, 1);
        chk(out_data == exp_q[0], "R5 first byte presented", out_data, exp_q[0]);
        run_frame(8'h02, 8'h66, 0);
        @(posedge clk); #1 out_ready = 1'b1;
        drained("R6 stalled block delivered once");
        run_frame(8'h02, 8'h66, 0);
        drained("R6 retried block delivered");

        // R7: partial block aborted by CS_n, then a full block
        cs_n = 1'b0;
        wait_n(HALF);
        frame_body(8'h03, 8'h77, 0, 10, 0);
        wait_n(HALF);
        cs_n = 1'b1;
        wait_n(4 * HALF);
        chk(out_valid == 1'b0, "R7 aborted block not released", out_valid, 0);
        run_frame(8'h03, 8'h88, 0);
        drained("R7 block after abort delivered");

        // R8: two blocks back to back under one chip select
        cs_n = 1'b0;
        wait_n(HALF);
        frame_body(8'h04, 8'h99, 0, FRAME_N, 1);
        frame_body(8'h05, 8'hAA, 0, FRAME_N, 1);
        wait_n(HALF);
        cs_n = 1'b1;
        drained("R8 back-to-back blocks delivered");
        chk(model_lg == 8'h05, "R8 model ack advanced", model_lg, 5);

        done = 1;
        finish_run();
    end

endmodule